// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a receive path and judges one frame at a time. The destination address arrives as six bytes, one per accepted cycle, in wire order. A start strobe marks the first of these bytes. While the bytes stream in, the block folds them into a CRC-32. It then compares the full address against a programmed station address, and looks up a bit in a 64-entry multicast hash table. Promiscuous mode and pass-all-multicast mode can override that lookup.

One cycle after the sixth byte arrives, the block raises a single-cycle valid pulse. In the same cycle it presents an accept flag and a reason code. Both stay in place until the next start strobe. Configuration comes in through a small write port with a select field, and each write takes effect at the next clock edge.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_reason` are all zero, and all configuration registers and mode bits are zero.
- R2: `dec_valid` is high for exactly one cycle: the cycle after the edge that captures the sixth address byte. `dec_accept` and `dec_reason` keep their value until the next `da_start`, which clears both. Bytes offered after the sixth and before the next start are ignored.
- R3: Writing `cfg_sel`=0 loads address bytes 0..3, with byte 0 in bits 7:0. Writing `cfg_sel`=1 loads bytes 4..5, with byte 4 in bits 7:0. Byte 0 is the first byte on the wire. When the hash-perfect bit is set and the address equals the station address, the frame is accepted with reason 3.
- R4: The hash index is bits 31:26 of a CRC-32 over the six bytes, computed with these rules:
  - polynomial 0x04C11DB7, shifted MSB-first;
  - initial value all ones, and no final inversion;
  - each byte fed LSB first.
  
  Index bit 5 selects the table word (`cfg_sel`=2 for the low word, 3 for the high word), and bits 4:0 select the bit within that word. When the hash-perfect bit is set, a group address whose table bit is 1 is accepted with reason 5.
- R5: `cfg_sel`=4 writes the mode bits: bit 0 promiscuous, bit 1 pass-all-multicast, bit 2 hash-perfect. With promiscuous set, every frame is accepted with reason 1, and this outranks every other reason.
- R6: The all-ones address is accepted with reason 2 under any setting of the mode bits other than promiscuous.
- R7: With pass-all-multicast set, any address whose group bit is set is accepted with reason 4, and the hash table is not consulted. The group bit is bit 0 of byte 0. Station match (reason 3) outranks this reason.
- R8: With the hash-perfect bit clear, neither a station match nor a hash hit accepts a frame.
- R9: A configuration write in the same cycle as the sixth byte does not affect that decision. It applies from the next frame on.
- R10: A rejected frame gives `dec_accept`=0 and reason 0. An accepted frame always carries a non-zero reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 station low, 1 station high, 2 hash low, 3 hash high, 4 mode |
| cfg_wdata | input | 32 | Configuration write data |
| da_start | input | 1 | Marks the first address byte and restarts collection |
| da_valid | input | 1 | Address byte valid |
| da_byte | input | 8 | Destination address byte, wire order |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 station, 4 all-multicast, 5 hash |

## Verification
A configuration write and the final address byte can fall in the same clock cycle. When that happens, the decision must be taken with the settings that were in force before the write. The bench provokes this by writing the mode register to promiscuous in the same cycle as the sixth byte of a non-matching unicast address. It then expects a rejection for that frame and a promiscuous accept for the frame that follows. Separately, the bench offers extra bytes after the sixth, in the cycles after the decision, and judges that neither the pulse nor the held decision changes.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        da_start,
  input  logic        da_valid,
  input  logic [7:0]  da_byte,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [2:0]  dec_reason
);
  localparam int AW  = 8 * ADDR_BYTES;
  localparam int CW  = $clog2(ADDR_BYTES + 1);
  localparam int TBL = 1 << HASH_BITS;

  localparam logic [2:0] RSN_NONE  = 3'd0;
  localparam logic [2:0] RSN_PROM  = 3'd1;
  localparam logic [2:0] RSN_BCAST = 3'd2;
  localparam logic [2:0] RSN_STA   = 3'd3;
  localparam logic [2:0] RSN_ALLM  = 3'd4;
  localparam logic [2:0] RSN_HASH  = 3'd5;

  logic [31:0]     sta_lo_q, hash_lo_q, hash_hi_q;
  logic [15:0]     sta_hi_q;
  logic [2:0]      mode_q;
  logic [AW-1:0]   addr_q;
  logic [31:0]     crc_q;
  logic [CW-1:0]   cnt_q;
  logic            col_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo_q  <= '0;
      sta_hi_q  <= '0;
      hash_lo_q <= '0;
      hash_hi_q <= '0;
      mode_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0:    sta_lo_q  <= cfg_wdata;
        3'd1:    sta_hi_q  <= cfg_wdata[15:0];
        3'd2:    hash_lo_q <= cfg_wdata;
        3'd3:    hash_hi_q <= cfg_wdata;
        3'd4:    mode_q    <= cfg_wdata[2:0];
        default: ;
      endcase
    end
  end

  wire              take    = da_valid && (da_start || col_q);
  wire [CW-1:0]     eff_cnt = da_start ? '0 : cnt_q;
  wire [31:0]       eff_crc = da_start ? 32'hFFFF_FFFF : crc_q;
  wire [AW-1:0]     eff_adr = da_start ? '0 : addr_q;
  wire [31:0]       crc_nxt = crc_byte(eff_crc, da_byte);
  wire              last    = take && (eff_cnt == CW'(ADDR_BYTES - 1));
  wire [AW-1:0]     fin_adr = {da_byte, eff_adr[AW-9:0]};

  wire [HASH_BITS-1:0] hidx  = crc_nxt[31 -: HASH_BITS];
  wire [TBL-1:0]       table_w = {hash_hi_q, hash_lo_q};
  wire                 hhit  = table_w[hidx];

  wire prom    = mode_q[0];
  wire allm    = mode_q[1];
  wire hp      = mode_q[2];
  wire grp     = fin_adr[0];
  wire bcast   = &fin_adr;
  wire sta_hit = (fin_adr == {sta_hi_q, sta_lo_q});

  wire acc_nxt = prom | bcast | (hp & sta_hit) | (allm & grp) | (hp & grp & hhit);

  logic [2:0] rsn_nxt;
  always_comb begin
    if (prom)                 rsn_nxt = RSN_PROM;
    else if (bcast)           rsn_nxt = RSN_BCAST;
    else if (hp && sta_hit)   rsn_nxt = RSN_STA;
    else if (allm && grp)     rsn_nxt = RSN_ALLM;
    else if (hp && grp && hhit) rsn_nxt = RSN_HASH;
    else                      rsn_nxt = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      crc_q  <= 32'hFFFF_FFFF;
      cnt_q  <= '0;
      col_q  <= 1'b0;
    end else begin
      if (da_start) begin
        addr_q <= '0;
        crc_q  <= 32'hFFFF_FFFF;
        cnt_q  <= '0;
        col_q  <= 1'b1;
      end
      if (take) begin
        addr_q[8*eff_cnt +: 8] <= da_byte;
        crc_q <= crc_nxt;
        cnt_q <= eff_cnt + CW'(1);
        if (last) col_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_NONE;
    end else begin
      dec_valid <= last;
      if (last) begin
        dec_accept <= acc_nxt;
        dec_reason <= rsn_nxt;
      end else if (da_start) begin
        dec_accept <= 1'b0;
        dec_reason <= RSN_NONE;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int CW = 3,
  parameter int ADDR_BYTES = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          da_start,
  input logic          da_valid,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic [2:0]    dec_reason,
  input logic          prom,
  input logic [CW-1:0] cnt
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2

  AST_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($past(da_valid) && !$past(da_start) && $past(cnt) == CW'(ADDR_BYTES - 1))); // R2

  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid && !$past(da_start)) |-> ($stable(dec_accept) && $stable(dec_reason))); // R2

  AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept == (dec_reason != 3'd0)); // R10

  AST_PROMISC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(prom)) |-> (dec_reason == 3'd1)); // R5
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.CW(CW), .ADDR_BYTES(ADDR_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .da_start(da_start), .da_valid(da_valid),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason),
  .prom(mode_q[0]), .cnt(cnt_q)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        da_start = 1'b0;
  logic        da_valid = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_addr_filter dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ a[8*b + i];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return c[31:26];
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [47:0] a, input bit coll, input logic [31:0] cdat);
    for (int i = 0; i < 6; i++) begin
      da_start = (i == 0); da_valid = 1'b1; da_byte = a[8*i +: 8];
      if (coll && i == 5) begin cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = cdat; end
      @(negedge clk);
    end
    da_start = 1'b0; da_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic expect_dec(input bit acc, input int rsn, input string tag);
    chk(dec_valid == 1'b1, {tag, " pulse"}, dec_valid, 1);
    chk(dec_accept == acc, {tag, " accept"}, dec_accept, acc);
    chk(dec_reason == rsn, {tag, " reason"}, dec_reason, rsn);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R2 pulse width", dec_valid, 0);
    chk(dec_accept == acc && dec_reason == rsn, "R2 held", dec_reason, rsn);
  endtask

  localparam logic [47:0] STA   = 48'h5544_3322_1100;
  localparam logic [47:0] OTHER = 48'h0011_2233_4454;
  localparam logic [47:0] MCAST = 48'hFB00_005E_0001;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  task automatic t_reset;
    chk(dec_valid == 0 && dec_accept == 0 && dec_reason == 0, "R1 reset", dec_reason, 0);
  endtask

  task automatic t_station;
    wr(3'd0, 32'h3322_1100); wr(3'd1, 32'h0000_5544); wr(3'd4, 32'h4);
    send(STA, 0, 0);   expect_dec(1, 3, "R3 station match");
    send(OTHER, 0, 0); expect_dec(0, 0, "R10 unicast reject");
    send(48'h0011_2233_4455, 0, 0); expect_dec(0, 0, "R3 reversed byte order");
  endtask

  task automatic t_hash;
    logic [5:0] ix;
    ix = hidx(MCAST);
    wr(3'd4, 32'h4);
    wr(ix[5] ? 3'd3 : 3'd2, 32'h1 << ix[4:0]);
    send(MCAST, 0, 0); expect_dec(1, 5, "R4 hash hit");
    wr(ix[5] ? 3'd3 : 3'd2, ~(32'h1 << ix[4:0]));
    send(MCAST, 0, 0); expect_dec(0, 0, "R4 hash miss");
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
  endtask

  task automatic t_hp_off;
    logic [5:0] ix;
    ix = hidx(MCAST);
    wr(ix[5] ? 3'd3 : 3'd2, 32'h1 << ix[4:0]);
    wr(3'd4, 32'h0);
    send(STA, 0, 0);   expect_dec(0, 0, "R8 station w/o enable");
    send(MCAST, 0, 0); expect_dec(0, 0, "R8 hash w/o enable");
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
  endtask

  task automatic t_bcast;
    wr(3'd4, 32'h0);
    send(BCAST, 0, 0); expect_dec(1, 2, "R6 broadcast no modes");
    wr(3'd4, 32'h6);
    send(BCAST, 0, 0); expect_dec(1, 2, "R6 broadcast with modes");
  endtask

  task automatic t_allmulti;
    wr(3'd4, 32'h2);
    send(MCAST, 0, 0); expect_dec(1, 4, "R7 all-multicast");
    send(OTHER, 0, 0); expect_dec(0, 0, "R7 unicast not passed");
  endtask

  task automatic t_promisc;
    wr(3'd4, 32'h1);
    send(OTHER, 0, 0); expect_dec(1, 1, "R5 promisc unicast");
    send(BCAST, 0, 0); expect_dec(1, 1, "R5 promisc over broadcast");
  endtask

  task automatic t_extra;
    wr(3'd4, 32'h4);
    send(STA, 0, 0);
    chk(dec_valid == 1, "R2 pulse before extra", dec_valid, 1);
    for (int i = 0; i < 4; i++) begin
      da_valid = 1'b1; da_byte = 8'hFF;
      @(negedge clk);
      chk(dec_valid == 0, "R2 extra byte no pulse", dec_valid, 0);
      chk(dec_accept == 1 && dec_reason == 3, "R2 extra byte held", dec_reason, 3);
    end
    da_valid = 1'b0;
    da_start = 1'b1; @(negedge clk); da_start = 1'b0;
    chk(dec_accept == 0 && dec_reason == 0, "R2 cleared by start", dec_reason, 0);
  endtask

  task automatic t_collide;
    wr(3'd4, 32'h0);
    send(OTHER, 1, 32'h1); expect_dec(0, 0, "R9 same-cycle write ignored");
    send(OTHER, 0, 0);     expect_dec(1, 1, "R9 write applies next frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_station();
    t_hash();
    t_hp_off();
    t_bcast();
    t_allmulti();
    t_promisc();
    t_extra();
    t_collide();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule